// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches page-table entries so that most virtual-to-physical translations finish without a memory access. A 20-bit virtual page number is looked up in 16 sets of 4 ways. On a hit the block returns the physical address, built from the stored physical page number and the unchanged 12-bit page offset, together with the entry's attribute bits. The same cycle's access-rights check turns a hit into a protection fault when the access is not allowed. A write to a page whose dirty flag is clear is reported as a miss so that the walker can set the flag in memory and refill the entry.

Entries are written from a fill port that carries the page walker's result. An invalidate command either drops every non-global entry or drops one page. Global entries survive the bulk flush. Replacement avoids them unless every way of the set is global. Within the set, an empty way is taken first; otherwise a tree pseudo-LRU picks the way.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is empty, `lk_hit_o` and `lk_fault_o` are 0, and any lookup misses.
- R2: A lookup asserted in cycle N answers in cycle N+1. The set is vpn[3:0] and the tag is vpn[19:4], where vpn is vaddr[31:12]. A hit needs a valid entry in that set with an equal tag. `lk_paddr_o` = {ppn, vaddr[11:0]}. With no lookup in cycle N, both flags are 0 in cycle N+1.
- R3: The attribute encoding is bit0 writable, bit1 user-accessible, bit2 cache-disable, bit3 write-through, bit4 dirty, bit5 global. A hit returns the stored attributes on `lk_attr_o`. When there is no hit, `lk_attr_o` and `lk_paddr_o` are 0.
- R4: A tag match reports `lk_fault_o`=1 and `lk_hit_o`=0 when a write meets bit0=0, or when a user access meets bit1=0.
- R5: A permitted write that matches an entry with bit4=0 reports neither hit nor fault.
- R6: A fill into a set with an empty way uses the lowest-numbered empty way.
- R7: A fill into a full set picks its victim with a 3-bit tree pseudo-LRU. At the root, 0 means left (ways 0-1) and 1 means right (ways 2-3); the leaf bits work the same way within each pair. Every allowed hit and every fill points the path bits away from the way it touched. Global ways are passed over unless all four ways are global.
- R8: The flush-non-global command drops every entry with bit5=0 and keeps every global entry.
- R9: The single-page invalidate drops the matching entry, global or not, and leaves the other entries intact.
- R10: A lookup issued in the same cycle as a fill sees the contents from before the fill.
- R11: A fill for a page already held overwrites that way, so no duplicate of the page remains.
- R12: When a fill and a flush-non-global fall in the same cycle, the filled entry remains valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_write_i | input | 1 | Lookup is a write |
| lk_user_i | input | 1 | Lookup is from user mode |
| lk_hit_o | output | 1 | Translation valid (one cycle after request) |
| lk_fault_o | output | 1 | Protection fault on a matching entry |
| lk_paddr_o | output | 32 | Physical address on a hit |
| lk_attr_o | output | 6 | Attribute bits of the hit entry |
| fill_valid_i | input | 1 | Write a walker result |
| fill_vpn_i | input | 20 | Virtual page number of the fill |
| fill_ppn_i | input | 20 | Physical page number of the fill |
| fill_attr_i | input | 6 | Attribute bits of the fill |
| inv_valid_i | input | 1 | Invalidate command |
| inv_all_i | input | 1 | 1: flush non-global entries, 0: flush one page |
| inv_vpn_i | input | 20 | Page to drop when inv_all_i is 0 |

## Verification
Two pairs of functions can fall in the same cycle: a lookup with a fill to the same page, and a fill with a bulk flush. The bench provokes the first by raising the lookup and the fill on the same falling edge for a page that is not held. It expects a miss in that answer and a hit on the next lookup. For the second, it raises a fill together with the flush-non-global command. It then expects the new page to hit and an older non-global page in the same set to miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ATTR_W = 6;

  typedef struct packed {
    logic glob;
    logic dirty;
    logic wt;
    logic cd;
    logic user;
    logic wr;
  } tlb_attr_t;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LVLS  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  glob_i,
  input  logic [WAYS-2:0]  plru_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAYS-1:0]  cand;
  logic [WAY_W-1:0] empty_way;
  logic [WAY_W-1:0] tree_way;

  always_comb begin
    empty_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) empty_way = WAY_W'(w);
    end
  end

  // non-global ways compete; an all-global set falls back to all ways
  always_comb begin
    cand = ~glob_i;
    if (cand == '0) cand = '1;
  end

  always_comb begin
    int   node;
    int   lo;
    int   span;
    logic l_any;
    logic r_any;
    logic go_r;
    node = 0;
    lo   = 0;
    for (int lvl = 0; lvl < LVLS; lvl++) begin
      span  = WAYS >> (lvl + 1);
      l_any = 1'b0;
      r_any = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (cand[w] && w >= lo && w < lo + span) l_any = 1'b1;
        if (cand[w] && w >= lo + span && w < lo + 2 * span) r_any = 1'b1;
      end
      go_r = plru_i[node] ? r_any : !l_any;
      if (go_r) lo = lo + span;
      node = 2 * node + 1 + int'(go_r);
    end
    tree_way = WAY_W'(lo);
  end

  assign victim_o = (&valid_i) ? tree_way : empty_way;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int OFS_W = 12,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  localparam int VA_W  = VPN_W + OFS_W,
  localparam int PA_W  = PPN_W + OFS_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic              lk_write_i,
  input  logic              lk_user_i,
  output logic              lk_hit_o,
  output logic              lk_fault_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic [ATTR_W-1:0] lk_attr_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic              inv_valid_i,
  input  logic              inv_all_i,
  input  logic [VPN_W-1:0]  inv_vpn_i
);
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [SETS-1:0][WAYS-2:0] plru_q, plru_nxt;
  logic [WAYS-1:0][TAG_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0][PPN_W-1:0] ppn_q  [SETS];
  tlb_attr_t [WAYS-1:0]       attr_q [SETS];

  function automatic logic [WAY_W-1:0] vec2idx(logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  function automatic logic [WAYS-2:0] plru_touch(logic [WAYS-2:0] b, logic [WAY_W-1:0] w);
    int   node;
    logic dir;
    node = 0;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      dir     = w[WAY_W-1-lvl];
      b[node] = !dir;
      node    = 2 * node + 1 + int'(dir);
    end
    return b;
  endfunction

  // ---- lookup
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_set;
  logic [WAYS-1:0]  lk_hvec;
  logic [WAY_W-1:0] lk_way;
  tlb_attr_t        lk_attr;
  logic             lk_match, lk_perm_bad, lk_clean_wr, lk_ok, lk_flt;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFS_W];
  assign lk_set = lk_vpn[IDX_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_i  (vld_q[lk_set]),
    .tags_i   (tag_q[lk_set]),
    .tag_i    (lk_vpn[VPN_W-1:IDX_W]),
    .hit_vec_o(lk_hvec)
  );

  assign lk_way      = vec2idx(lk_hvec);
  assign lk_match    = |lk_hvec;
  assign lk_attr     = attr_q[lk_set][lk_way];
  assign lk_perm_bad = (lk_write_i && !lk_attr.wr) || (lk_user_i && !lk_attr.user);
  assign lk_clean_wr = lk_write_i && !lk_attr.dirty;
  assign lk_ok       = lk_valid_i && lk_match && !lk_perm_bad && !lk_clean_wr;
  assign lk_flt      = lk_valid_i && lk_match && lk_perm_bad;

  // ---- fill
  logic [IDX_W-1:0] fl_set;
  logic [WAYS-1:0]  fl_hvec, fl_glob;
  logic [WAY_W-1:0] fl_vict, fl_way;

  assign fl_set = fill_vpn_i[IDX_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .valid_i  (vld_q[fl_set]),
    .tags_i   (tag_q[fl_set]),
    .tag_i    (fill_vpn_i[VPN_W-1:IDX_W]),
    .hit_vec_o(fl_hvec)
  );

  always_comb begin
    for (int w = 0; w < WAYS; w++) fl_glob[w] = attr_q[fl_set][w].glob;
  end

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (vld_q[fl_set]),
    .glob_i  (fl_glob),
    .plru_i  (plru_q[fl_set]),
    .victim_o(fl_vict)
  );

  // refill of a resident page reuses its way
  assign fl_way = (|fl_hvec) ? vec2idx(fl_hvec) : fl_vict;

  // ---- single-page invalidate
  logic [IDX_W-1:0] iv_set;
  logic [WAYS-1:0]  iv_hvec;

  assign iv_set = inv_vpn_i[IDX_W-1:0];

  tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_iv_match (
    .valid_i  (vld_q[iv_set]),
    .tags_i   (tag_q[iv_set]),
    .tag_i    (inv_vpn_i[VPN_W-1:IDX_W]),
    .hit_vec_o(iv_hvec)
  );

  // ---- replacement state
  always_comb begin
    plru_nxt = plru_q;
    if (lk_ok) plru_nxt[lk_set] = plru_touch(plru_q[lk_set], lk_way);
    if (fill_valid_i) plru_nxt[fl_set] = plru_touch(plru_nxt[fl_set], fl_way);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q      <= '0;
      plru_q     <= '0;
      lk_hit_o   <= 1'b0;
      lk_fault_o <= 1'b0;
      lk_paddr_o <= '0;
      lk_attr_o  <= '0;
    end else begin
      plru_q     <= plru_nxt;
      lk_hit_o   <= lk_ok;
      lk_fault_o <= lk_flt;
      lk_paddr_o <= lk_ok ? {ppn_q[lk_set][lk_way], lk_vaddr_i[OFS_W-1:0]} : '0;
      lk_attr_o  <= lk_ok ? lk_attr : '0;
      if (inv_valid_i) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) begin
            if (inv_all_i) begin
              if (!attr_q[s][w].glob) vld_q[s][w] <= 1'b0;
            end else if (IDX_W'(s) == iv_set && iv_hvec[w]) begin
              vld_q[s][w] <= 1'b0;
            end
          end
        end
      end
      if (fill_valid_i) vld_q[fl_set][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_valid_i) begin
      tag_q[fl_set][fl_way]  <= fill_vpn_i[VPN_W-1:IDX_W];
      ppn_q[fl_set][fl_way]  <= fill_ppn_i;
      attr_q[fl_set][fl_way] <= tlb_attr_t'(fill_attr_i);
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFS_W  = 12,
  parameter int ATTR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [VA_W-1:0]   lk_vaddr_i,
  input logic              lk_write_i,
  input logic              lk_user_i,
  input logic              lk_hit_o,
  input logic              lk_fault_o,
  input logic [PA_W-1:0]   lk_paddr_o,
  input logic [ATTR_W-1:0] lk_attr_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lk_valid_i) |-> (!lk_hit_o && !lk_fault_o));

  assert_offset_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[OFS_W-1:0] == $past(lk_vaddr_i[OFS_W-1:0])));

  assert_miss_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (lk_paddr_o == '0 && lk_attr_o == '0));

  assert_fault_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> ($past(lk_write_i) || $past(lk_user_i)));

  assert_user_allowed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && $past(lk_user_i)) |-> lk_attr_o[1]);

  assert_write_dirty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && $past(lk_write_i)) |-> (lk_attr_o[4] && lk_attr_o[0]));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ATTR_W(tlb_pkg::ATTR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i),
  .lk_write_i(lk_write_i), .lk_user_i(lk_user_i), .lk_hit_o(lk_hit_o),
  .lk_fault_o(lk_fault_o), .lk_paddr_o(lk_paddr_o), .lk_attr_o(lk_attr_o)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic [5:0]  lk_attr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [5:0]  fill_attr = '0;
  logic        inv_valid = 1'b0, inv_all = 1'b0;
  logic [19:0] inv_vpn = '0;
  int total = 0, bad = 0;

  localparam logic [11:0] OFS = 12'h5C3;

  always #2 clk = ~clk;

  tlb_xlate i_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_write_i(lk_write), .lk_user_i(lk_user),
    .lk_hit_o(lk_hit), .lk_fault_o(lk_fault), .lk_paddr_o(lk_paddr), .lk_attr_o(lk_attr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .fill_attr_i(fill_attr),
    .inv_valid_i(inv_valid), .inv_all_i(inv_all), .inv_vpn_i(inv_vpn)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [5:0] attr);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_attr = attr;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inv(input logic all, input logic [19:0] vpn);
    @(negedge clk);
    inv_valid = 1'b1; inv_all = all; inv_vpn = vpn;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic expect_look(input logic [19:0] vpn, input logic wr, input logic us,
                             input logic eh, input logic ef, input logic [19:0] eppn,
                             input logic [5:0] eattr, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, OFS}; lk_write = wr; lk_user = us;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_hit == eh, {req, " hit"}, 64'(lk_hit), 64'(eh));
    check(lk_fault == ef, {req, " fault"}, 64'(lk_fault), 64'(ef));
    if (eh) begin
      check(lk_paddr == {eppn, OFS}, {req, " paddr"}, 64'(lk_paddr), 64'({eppn, OFS}));
      check(lk_attr == eattr, {req, " attr"}, 64'(lk_attr), 64'(eattr));
    end
  endtask

  // op: 0 fill, 1 lookup, 3 page invalidate
  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [5:0]  attr;
    logic        wr;
    logic        us;
    logic        eh;
    logic        ef;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 20'h00010, 20'h0AAAA, 6'h13, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 fill
    '{2'd1, 20'h00010, 20'h0AAAA, 6'h13, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 R3 read hit
    '{2'd1, 20'h00010, 20'h0AAAA, 6'h13, 1'b1, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 write hit
    '{2'd1, 20'h00020, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 same set, other tag
    '{2'd0, 20'h00031, 20'h0BBBB, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{2'd1, 20'h00031, 20'h0BBBB, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 allowed read
    '{2'd1, 20'h00031, 20'h00000, 6'h00, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 write read-only
    '{2'd1, 20'h00031, 20'h00000, 6'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 user on supervisor
    '{2'd0, 20'h00042, 20'h0CCCC, 6'h0D, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{2'd1, 20'h00042, 20'h00000, 6'h0D, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 clean write misses
    '{2'd1, 20'h00042, 20'h0CCCC, 6'h0D, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},
    '{2'd0, 20'h00042, 20'h0DDDD, 6'h1D, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 refill
    '{2'd1, 20'h00042, 20'h0DDDD, 6'h1D, 1'b1, 1'b0, 1'b1, 1'b0, 4'd11},
    '{2'd3, 20'h00042, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 drop page
    '{2'd1, 20'h00042, 20'h00000, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 no stale copy
    '{2'd1, 20'h00010, 20'h0AAAA, 6'h13, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9}   // R9 neighbour kept
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lk_hit == 1'b0 && lk_fault == 1'b0, "R1 reset outputs", 64'({lk_hit, lk_fault}), 64'(0));
    rst_n = 1'b1;
    expect_look(20'h00010, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R1 empty after reset");

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0:    do_fill(VEC[i].vpn, VEC[i].ppn, VEC[i].attr);
        2'd3:    do_inv(1'b0, VEC[i].vpn);
        default: expect_look(VEC[i].vpn, VEC[i].wr, VEC[i].us, VEC[i].eh, VEC[i].ef,
                             VEC[i].ppn, VEC[i].attr, tag);
      endcase
    end

    // R6 R7: set 4, empty ways in order, then touch way 0 -> victim way 2
    for (int k = 0; k < 4; k++) do_fill(20'h00104 + 20'(k * 16), 20'h10000 + 20'(k), 6'h13);
    expect_look(20'h00104, 1'b0, 1'b0, 1'b1, 1'b0, 20'h10000, 6'h13, "R7 touch way0");
    do_fill(20'h00144, 20'h10004, 6'h13);
    expect_look(20'h00124, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R7 plru victim evicted");
    expect_look(20'h00114, 1'b0, 1'b0, 1'b1, 1'b0, 20'h10001, 6'h13, "R6 way1 kept");
    expect_look(20'h00144, 1'b0, 1'b0, 1'b1, 1'b0, 20'h10004, 6'h13, "R7 new entry");

    // R7: set 5, global way 0 skipped -> way 1 replaced
    do_fill(20'h00105, 20'h20000, 6'h33);
    for (int k = 1; k < 4; k++) do_fill(20'h00105 + 20'(k * 16), 20'h20000 + 20'(k), 6'h13);
    do_fill(20'h00145, 20'h20004, 6'h13);
    expect_look(20'h00115, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R7 non-global victim");
    expect_look(20'h00105, 1'b0, 1'b0, 1'b1, 1'b0, 20'h20000, 6'h33, "R7 global retained");

    // R7: set 6 all global -> way 0 replaced
    for (int k = 0; k < 5; k++) do_fill(20'h00106 + 20'(k * 16), 20'h30000 + 20'(k), 6'h33);
    expect_look(20'h00106, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R7 all-global victim");
    expect_look(20'h00146, 1'b0, 1'b0, 1'b1, 1'b0, 20'h30004, 6'h33, "R7 all-global fill");

    // R8 flush non-global
    do_inv(1'b1, '0);
    expect_look(20'h00105, 1'b0, 1'b0, 1'b1, 1'b0, 20'h20000, 6'h33, "R8 global survives");
    expect_look(20'h00125, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R8 non-global dropped");
    expect_look(20'h00010, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R8 non-global dropped b");
    expect_look(20'h00136, 1'b0, 1'b0, 1'b1, 1'b0, 20'h30003, 6'h33, "R8 global survives b");

    // R9 single-page invalidate of a global entry
    do_inv(1'b0, 20'h00105);
    expect_look(20'h00105, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R9 global page dropped");
    expect_look(20'h00146, 1'b0, 1'b0, 1'b1, 1'b0, 20'h30004, 6'h33, "R9 other set kept");

    // R10 fill and lookup of the same page in one cycle
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00207; fill_ppn = 20'h40000; fill_attr = 6'h13;
    lk_valid = 1'b1; lk_vaddr = {20'h00207, OFS}; lk_write = 1'b0; lk_user = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    check(lk_hit == 1'b0, "R10 lookup sees old contents", 64'(lk_hit), 64'(0));
    expect_look(20'h00207, 1'b0, 1'b0, 1'b1, 1'b0, 20'h40000, 6'h13, "R10 next lookup hits");

    // R12 fill together with flush non-global
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00217; fill_ppn = 20'h40001; fill_attr = 6'h13;
    inv_valid = 1'b1; inv_all = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; inv_valid = 1'b0;
    expect_look(20'h00217, 1'b0, 1'b0, 1'b1, 1'b0, 20'h40001, 6'h13, "R12 fill kept");
    expect_look(20'h00207, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R12 old entry flushed");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule